// File: doc/BRIEF.md
# Windowed Readout Address Sequencer

This block produces the row (X) and column (Y) pixel addresses used to read a rectangular window out of a 1026 by 1026 random-access image array. A host writes the window's X and Y start addresses, its width and height (each as a count minus one), a counting direction for each axis and a line-advance mode. A start command then opens the window. Each element-rate strobe consumes the addressed pixel and moves the Y counter one step along the current line. When a line has been consumed, Y goes back to its start value and X moves to the next line.

X can move to the next line in one of two ways. In manual mode the sequencer waits for a separate line strobe. In self-advancing mode X steps in the same cycle that the line completes, so a single element-rate strobe is enough to walk the whole array. After the last pixel of the last line, both counters return to their start values and the sequencer goes idle. The same window can then be started again at once. Both axes wrap modulo 1026, and any wrap leaves a sticky range flag set.

Top module: `subwin_addr_seq`

## Requirements
- R1: After reset the sequencer is idle, both addresses are 0, and pix_valid, eol, eow, range_err and load_rej are all 0.
- R2: A cfg_load taken while idle sets the addresses to the new X and Y starts on the next cycle. A start value of 1026 or more is reduced by 1026 and sets range_err. A load whose starts are both in range clears range_err.
- R3: While a line is active (pix_valid = 1), each elem_stb moves y_addr by one step, upward when cfg_y_down = 0 and downward when it is 1, until the line is complete.
- R4: The elem_stb that consumes pixel number cfg_width_m1 + 1 of a line puts y_addr back to the Y start, and eol is 1 for exactly the following cycle.
- R5: In manual mode (cfg_self_adv = 0), after a line that is not the last one, pix_valid is 0 and elem_stb has no effect until a line_stb. The line_stb moves x_addr by one step in the direction given by cfg_x_down (0 = up) and opens the next line.
- R6: In self-advancing mode (cfg_self_adv = 1), x_addr steps in the same cycle that Y reloads at a line end, with no line_stb needed.
- R7: After cfg_height_m1 + 1 lines, eow and eol are both 1 for one cycle, both addresses are back at their starts, and the sequencer is idle. A start issued in the next cycle reopens the same window.
- R8: Stepping up from 1025 gives 0 and stepping down from 0 gives 1025. Either wrap sets range_err, which stays set until an in-range load is accepted.
- R9: A cfg_load while busy changes neither the addresses nor the window, and sets load_rej. load_rej stays set until a load is accepted.
- R10: start is ignored while busy or when it arrives in the same cycle as cfg_load. line_stb is ignored unless the sequencer is waiting between lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load the window configuration (taken only when idle) |
| cfg_x_start | input | 11 | First line (X) address |
| cfg_y_start | input | 11 | First pixel (Y) address of every line |
| cfg_width_m1 | input | 11 | Pixels per line minus one |
| cfg_height_m1 | input | 11 | Lines per window minus one |
| cfg_x_down | input | 1 | X counts down when 1 |
| cfg_y_down | input | 1 | Y counts down when 1 |
| cfg_self_adv | input | 1 | Advance X internally at each line end |
| start | input | 1 | Open the loaded window |
| elem_stb | input | 1 | Element-rate strobe, consumes one pixel |
| line_stb | input | 1 | Line strobe, moves to the next line in manual mode |
| x_addr | output | 11 | Current line address |
| y_addr | output | 11 | Current pixel address |
| pix_valid | output | 1 | Addresses point at a pixel that can be consumed |
| busy | output | 1 | A window is open |
| eol | output | 1 | One-cycle pulse after a line's last pixel |
| eow | output | 1 | One-cycle pulse after the window's last pixel |
| range_err | output | 1 | Sticky wrap or reduced-start flag |
| load_rej | output | 1 | Sticky flag for a load refused while busy |

## Verification
The assertions check several things on every cycle. Both addresses stay inside 0..1025. Every consumed pixel moves Y by one step modulo 1026, or else ends the line. eol always lands on the Y start, and eow always lands on the X start with the sequencer idle. The idle and between-lines states keep both addresses still, and the two sticky flags never clear without a load. The bench scenarios are needed for the rest: the exact pixel and line counts at which eol and eow fire, the direction and mode settings, the reduction of out-of-range starts, and the immediate restart of a finished window. A behavioural model compares all outputs on every clock.

// File: rtl/subwin_pkg.sv
// Shared constants and types for the windowed readout address sequencer.
// Assumes a square array whose address fits in ADDR_W bits.
package subwin_pkg;
    localparam int unsigned ADDR_W    = 11;
    localparam int unsigned ARRAY_DIM = 1026;

    // Sequencer phase: idle, consuming a line, or waiting between lines
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/subwin_axis_cnt.sv
// Preloadable up/down address counter for one array axis.
// Counts modulo DIM. A load has priority over a step in the same cycle.
// Assumes load_val is already below DIM. wrap pulses combinationally
// when a step crosses the boundary.
module subwin_axis_cnt #(
    parameter int unsigned AW  = 11,
    parameter int unsigned DIM = 1026
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          dir_down,
    output logic [AW-1:0] cnt,
    output logic          wrap
);
    localparam logic [AW-1:0] LAST = AW'(DIM - 1);

    logic [AW-1:0] cnt_q;
    logic [AW-1:0] stepped;

    // Next address for a single step in the chosen direction
    always_comb begin
        if (dir_down) stepped = (cnt_q == '0) ? LAST : cnt_q - 1'b1;
        else          stepped = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Counter register: load first, then step
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= stepped;
    end

    assign wrap = step && !load && (dir_down ? (cnt_q == '0) : (cnt_q == LAST));
    assign cnt  = cnt_q;
endmodule

// File: rtl/subwin_span_track.sv
// Counts pixels consumed in the current line and lines opened in the window.
// Raises last_pix and last_line when the counts reach the programmed
// "minus one" limits. Assumes the limits stay stable while a window is open.
module subwin_span_track #(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          pix_adv,
    input  logic          pix_clr,
    input  logic          line_adv,
    input  logic [AW-1:0] pix_last_idx,
    input  logic [AW-1:0] line_last_idx,
    output logic          last_pix,
    output logic          last_line
);
    logic [AW-1:0] pix_cnt;
    logic [AW-1:0] line_cnt;

    // Pixel index within the current line
    always_ff @(posedge clk) begin
        if (!rst_n)                  pix_cnt <= '0;
        else if (restart || pix_clr) pix_cnt <= '0;
        else if (pix_adv)            pix_cnt <= pix_cnt + 1'b1;
    end

    // Line index within the window
    always_ff @(posedge clk) begin
        if (!rst_n)        line_cnt <= '0;
        else if (restart)  line_cnt <= '0;
        else if (line_adv) line_cnt <= line_cnt + 1'b1;
    end

    assign last_pix  = (pix_cnt == pix_last_idx);
    assign last_line = (line_cnt == line_last_idx);
endmodule

// File: rtl/subwin_seq_ctrl.sv
// Phase controller of the window sequencer. Decides when each counter
// steps or reloads, and produces the line and window pulses and the sticky
// flags. Assumes the strobes are single-cycle enables synchronous to clk.
module subwin_seq_ctrl
    import subwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  logic cfg_oor,
    input  logic start,
    input  logic elem_stb,
    input  logic line_stb,
    input  logic self_adv,
    input  logic last_pix,
    input  logic last_line,
    input  logic wrap_any,
    output logic cfg_take,
    output logic run_start,
    output logic y_step,
    output logic y_reload,
    output logic x_step,
    output logic x_reload,
    output logic pix_clr,
    output logic busy,
    output logic pix_valid,
    output logic eol,
    output logic eow,
    output logic range_err,
    output logic load_rej
);
    seq_state_t state_q, state_d;
    logic consume, line_done, win_done, gap_exit, auto_step;
    logic eol_q, eow_q, range_q, rej_q;

    // Strobe qualification against the current phase
    always_comb begin
        cfg_take  = (state_q == SEQ_IDLE) && cfg_load;
        run_start = (state_q == SEQ_IDLE) && start && !cfg_load;
        consume   = (state_q == SEQ_RUN) && elem_stb;
        line_done = consume && last_pix;
        win_done  = line_done && last_line;
        gap_exit  = (state_q == SEQ_GAP) && line_stb;
        auto_step = line_done && !last_line && self_adv;
    end

    // Counter commands
    always_comb begin
        y_step   = consume && !last_pix;
        y_reload = line_done || cfg_take;
        x_step   = gap_exit || auto_step;
        x_reload = win_done || cfg_take;
        pix_clr  = line_done;
    end

    // Next phase
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (run_start) state_d = SEQ_RUN;
            SEQ_RUN: begin
                if (win_done)                   state_d = SEQ_IDLE;
                else if (line_done && !self_adv) state_d = SEQ_GAP;
            end
            SEQ_GAP:  if (gap_exit) state_d = SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Line and window pulses, one cycle after the consuming strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eol_q <= 1'b0;
            eow_q <= 1'b0;
        end else begin
            eol_q <= line_done;
            eow_q <= win_done;
        end
    end

    // Sticky range flag: set on any wrap or reduced start, cleared by a clean load
    always_ff @(posedge clk) begin
        if (!rst_n)                          range_q <= 1'b0;
        else if (wrap_any)                   range_q <= 1'b1;
        else if (cfg_take)                   range_q <= cfg_oor;
    end

    // Sticky refused-load flag
    always_ff @(posedge clk) begin
        if (!rst_n)                              rej_q <= 1'b0;
        else if (cfg_load && state_q != SEQ_IDLE) rej_q <= 1'b1;
        else if (cfg_take)                       rej_q <= 1'b0;
    end

    assign busy      = (state_q != SEQ_IDLE);
    assign pix_valid = (state_q == SEQ_RUN);
    assign eol       = eol_q;
    assign eow       = eow_q;
    assign range_err = range_q;
    assign load_rej  = rej_q;
endmodule

// File: rtl/subwin_addr_seq.sv
// Top of the windowed readout address sequencer. Holds the window
// configuration, reduces out-of-range starts modulo the array size, and
// joins the two axis counters, the span tracker and the phase controller.
// Assumes configuration inputs are sampled only on an accepted load.
module subwin_addr_seq
    import subwin_pkg::*;
#(
    parameter int unsigned ADDR_W    = subwin_pkg::ADDR_W,
    parameter int unsigned ARRAY_DIM = subwin_pkg::ARRAY_DIM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_x_start,
    input  logic [ADDR_W-1:0] cfg_y_start,
    input  logic [ADDR_W-1:0] cfg_width_m1,
    input  logic [ADDR_W-1:0] cfg_height_m1,
    input  logic              cfg_x_down,
    input  logic              cfg_y_down,
    input  logic              cfg_self_adv,
    input  logic              start,
    input  logic              elem_stb,
    input  logic              line_stb,
    output logic [ADDR_W-1:0] x_addr,
    output logic [ADDR_W-1:0] y_addr,
    output logic              pix_valid,
    output logic              busy,
    output logic              eol,
    output logic              eow,
    output logic              range_err,
    output logic              load_rej
);
    localparam logic [ADDR_W-1:0] DIM_V = ADDR_W'(ARRAY_DIM);

    logic [ADDR_W-1:0] x_start_q, y_start_q, width_q, height_q;
    logic              x_down_q, y_down_q, self_adv_q;
    logic [ADDR_W-1:0] x_in_red, y_in_red, x_load_val, y_load_val;
    logic              x_in_oor, y_in_oor;
    logic              cfg_take, run_start, y_step, y_reload, x_step, x_reload, pix_clr;
    logic              last_pix, last_line, x_wrap, y_wrap;

    // Reduce incoming starts into the array range
    always_comb begin
        x_in_oor = (cfg_x_start >= DIM_V);
        y_in_oor = (cfg_y_start >= DIM_V);
        x_in_red = x_in_oor ? cfg_x_start - DIM_V : cfg_x_start;
        y_in_red = y_in_oor ? cfg_y_start - DIM_V : cfg_y_start;
    end

    // Window configuration registers, written only on an accepted load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_start_q  <= '0;
            y_start_q  <= '0;
            width_q    <= '0;
            height_q   <= '0;
            x_down_q   <= 1'b0;
            y_down_q   <= 1'b0;
            self_adv_q <= 1'b0;
        end else if (cfg_take) begin
            x_start_q  <= x_in_red;
            y_start_q  <= y_in_red;
            width_q    <= cfg_width_m1;
            height_q   <= cfg_height_m1;
            x_down_q   <= cfg_x_down;
            y_down_q   <= cfg_y_down;
            self_adv_q <= cfg_self_adv;
        end
    end

    // Preload source: fresh configuration on a load, stored start otherwise
    always_comb begin
        x_load_val = cfg_take ? x_in_red : x_start_q;
        y_load_val = cfg_take ? y_in_red : y_start_q;
    end

    subwin_axis_cnt #(.AW(ADDR_W), .DIM(ARRAY_DIM)) u_x_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (x_reload),
        .load_val (x_load_val),
        .step     (x_step),
        .dir_down (x_down_q),
        .cnt      (x_addr),
        .wrap     (x_wrap)
    );

    subwin_axis_cnt #(.AW(ADDR_W), .DIM(ARRAY_DIM)) u_y_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (y_reload),
        .load_val (y_load_val),
        .step     (y_step),
        .dir_down (y_down_q),
        .cnt      (y_addr),
        .wrap     (y_wrap)
    );

    subwin_span_track #(.AW(ADDR_W)) u_span (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart       (run_start),
        .pix_adv       (y_step),
        .pix_clr       (pix_clr),
        .line_adv      (x_step),
        .pix_last_idx  (width_q),
        .line_last_idx (height_q),
        .last_pix      (last_pix),
        .last_line     (last_line)
    );

    subwin_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_oor   (x_in_oor || y_in_oor),
        .start     (start),
        .elem_stb  (elem_stb),
        .line_stb  (line_stb),
        .self_adv  (self_adv_q),
        .last_pix  (last_pix),
        .last_line (last_line),
        .wrap_any  (x_wrap || y_wrap),
        .cfg_take  (cfg_take),
        .run_start (run_start),
        .y_step    (y_step),
        .y_reload  (y_reload),
        .x_step    (x_step),
        .x_reload  (x_reload),
        .pix_clr   (pix_clr),
        .busy      (busy),
        .pix_valid (pix_valid),
        .eol       (eol),
        .eow       (eow),
        .range_err (range_err),
        .load_rej  (load_rej)
    );
endmodule

// File: rtl/subwin_addr_seq_chk.sv
// Property checker for the windowed readout address sequencer, bound to
// the top. It observes ports plus the stored start addresses.
module subwin_addr_seq_chk #(
    parameter int unsigned AW  = 11,
    parameter int unsigned DIM = 1026
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_load,
    input logic          elem_stb,
    input logic          line_stb,
    input logic [AW-1:0] x_addr,
    input logic [AW-1:0] y_addr,
    input logic          pix_valid,
    input logic          busy,
    input logic          eol,
    input logic          eow,
    input logic          range_err,
    input logic          load_rej,
    input logic [AW-1:0] x_start_q,
    input logic [AW-1:0] y_start_q
);
    localparam logic [AW-1:0] LAST = AW'(DIM - 1);

    // R8
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_addr <= LAST) && (y_addr <= LAST));

    // R3
    y_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && elem_stb) |=> (eol ||
            (y_addr == (($past(y_addr) == LAST) ? '0 : $past(y_addr) + 1'b1)) ||
            (y_addr == (($past(y_addr) == '0) ? LAST : $past(y_addr) - 1'b1))));

    // R4
    eol_at_y_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eol |-> (y_addr == y_start_q));

    // R7
    eow_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eow |-> (eol && !busy && x_addr == x_start_q));

    // R5
    gap_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pix_valid && !line_stb) |=> ($stable(x_addr) && $stable(y_addr) && busy && !pix_valid));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_load) |=> ($stable(x_addr) && $stable(y_addr)));

    // R9
    rej_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rej && !cfg_load) |=> load_rej);

    // R8
    range_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (range_err && !cfg_load) |=> range_err);

    // R5
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy);
endmodule

bind subwin_addr_seq subwin_addr_seq_chk #(.AW(ADDR_W), .DIM(ARRAY_DIM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .elem_stb  (elem_stb),
    .line_stb  (line_stb),
    .x_addr    (x_addr),
    .y_addr    (y_addr),
    .pix_valid (pix_valid),
    .busy      (busy),
    .eol       (eol),
    .eow       (eow),
    .range_err (range_err),
    .load_rej  (load_rej),
    .x_start_q (x_start_q),
    .y_start_q (y_start_q)
);

// File: tb/subwin_addr_seq_bench.sv
// Self-checking bench: directed scenarios plus a behavioural model
// compared against every output on every clock.
module subwin_addr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIM        = 1026;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0, cfg_x_down = 1'b0, cfg_y_down = 1'b0, cfg_self_adv = 1'b0;
    logic [10:0] cfg_x_start = '0, cfg_y_start = '0, cfg_width_m1 = '0, cfg_height_m1 = '0;
    logic        start = 1'b0, elem_stb = 1'b0, line_stb = 1'b0;
    logic [10:0] x_addr, y_addr;
    logic        pix_valid, busy, eol, eow, range_err, load_rej;

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;

    // Model state: 0 idle, 1 running a line, 2 waiting between lines
    int m_st, m_x, m_y, m_pix, m_line, m_xs, m_ys, m_w, m_h;
    bit m_xd, m_yd, m_auto, m_eol, m_eow, m_rng, m_rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    subwin_addr_seq u_subwin_addr_seq (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_x_start(cfg_x_start), .cfg_y_start(cfg_y_start),
        .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1),
        .cfg_x_down(cfg_x_down), .cfg_y_down(cfg_y_down), .cfg_self_adv(cfg_self_adv),
        .start(start), .elem_stb(elem_stb), .line_stb(line_stb),
        .x_addr(x_addr), .y_addr(y_addr), .pix_valid(pix_valid), .busy(busy),
        .eol(eol), .eow(eow), .range_err(range_err), .load_rej(load_rej)
    );

    function automatic int step_of(int v, bit dn);
        if (dn) return (v == 0) ? DIM - 1 : v - 1;
        return (v == DIM - 1) ? 0 : v + 1;
    endfunction

    function automatic bit wraps(int v, bit dn);
        return dn ? (v == 0) : (v == DIM - 1);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, updated at each rising edge from the applied inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_x = 0; m_y = 0; m_pix = 0; m_line = 0;
            m_xs = 0; m_ys = 0; m_w = 0; m_h = 0;
            m_xd = 0; m_yd = 0; m_auto = 0;
            m_eol = 0; m_eow = 0; m_rng = 0; m_rej = 0;
        end else begin
            m_eol = 0; m_eow = 0;
            if (m_st == 0) begin
                if (cfg_load) begin
                    m_xs = (int'(cfg_x_start) >= DIM) ? int'(cfg_x_start) - DIM : int'(cfg_x_start);
                    m_ys = (int'(cfg_y_start) >= DIM) ? int'(cfg_y_start) - DIM : int'(cfg_y_start);
                    m_rng = (int'(cfg_x_start) >= DIM) || (int'(cfg_y_start) >= DIM);
                    m_w = cfg_width_m1; m_h = cfg_height_m1;
                    m_xd = cfg_x_down; m_yd = cfg_y_down; m_auto = cfg_self_adv;
                    m_x = m_xs; m_y = m_ys; m_rej = 0;
                end else if (start) begin
                    m_st = 1; m_pix = 0; m_line = 0;
                end
            end else begin
                if (cfg_load) m_rej = 1;
                if (m_st == 1 && elem_stb) begin
                    if (m_pix == m_w) begin
                        m_eol = 1; m_y = m_ys; m_pix = 0;
                        if (m_line == m_h) begin
                            m_eow = 1; m_x = m_xs; m_st = 0;
                        end else if (m_auto) begin
                            if (wraps(m_x, m_xd)) m_rng = 1;
                            m_x = step_of(m_x, m_xd); m_line++;
                        end else m_st = 2;
                    end else begin
                        if (wraps(m_y, m_yd)) m_rng = 1;
                        m_y = step_of(m_y, m_yd); m_pix++;
                    end
                end else if (m_st == 2 && line_stb) begin
                    if (wraps(m_x, m_xd)) m_rng = 1;
                    m_x = step_of(m_x, m_xd); m_line++; m_st = 1;
                end
            end
        end
    end

    // Compare every output against the model, away from the rising edge
    always @(negedge clk) begin
        if (compare_on) begin
            check("R3 x_addr", x_addr, m_x);
            check("R3 y_addr", y_addr, m_y);
            check("R5 pix_valid", pix_valid, m_st == 1);
            check("R7 busy", busy, m_st != 0);
            check("R4 eol", eol, m_eol);
            check("R7 eow", eow, m_eow);
            check("R8 range_err", range_err, m_rng);
            check("R9 load_rej", load_rej, m_rej);
        end
    end

    task automatic load_cfg(int xs, int ys, int w, int h, bit xd, bit yd, bit adv);
        cfg_x_start = 11'(xs); cfg_y_start = 11'(ys);
        cfg_width_m1 = 11'(w); cfg_height_m1 = 11'(h);
        cfg_x_down = xd; cfg_y_down = yd; cfg_self_adv = adv;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_line();
        line_stb = 1'b1; @(negedge clk); line_stb = 1'b0;
    endtask

    task automatic run_elems(int n);
        elem_stb = 1'b1; repeat (n) @(negedge clk); elem_stb = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1'b1;
        // R1: reset state
        check("R1 x_addr", x_addr, 0);
        check("R1 y_addr", y_addr, 0);
        check("R1 busy", busy, 0);
        check("R1 flags", {eol, eow, range_err, load_rej, pix_valid}, 0);

        // Manual mode, 3 x 2 window counting up
        load_cfg(10, 20, 2, 1, 0, 0, 0);
        check("R2 x start", x_addr, 10);
        check("R2 y start", y_addr, 20);
        pulse_start();
        run_elems(1);
        check("R3 y up", y_addr, 21);
        run_elems(2);
        check("R4 y reload", y_addr, 20);
        check("R4 eol", eol, 1);
        check("R5 wait", pix_valid, 0);
        run_elems(2);
        check("R5 elem ignored", y_addr, 20);
        check("R5 x held", x_addr, 10);
        pulse_line();
        check("R5 x step", x_addr, 11);
        run_elems(3);
        check("R7 eow", eow, 1);
        check("R7 idle", busy, 0);
        check("R7 x back", x_addr, 10);
        pulse_start();
        check("R7 restart", busy, 1);
        load_cfg(500, 500, 0, 0, 0, 0, 0);
        check("R9 x unchanged", x_addr, 10);
        check("R9 load_rej", load_rej, 1);
        pulse_start();
        run_elems(3); pulse_line(); run_elems(3);
        check("R9 window unchanged", busy, 0);

        // Self-advancing mode, 4 x 3 window counting down
        load_cfg(5, 3, 3, 2, 1, 1, 1);
        check("R9 rej cleared", load_rej, 0);
        pulse_start();
        pulse_line();
        check("R10 line ignored", x_addr, 5);
        run_elems(4);
        check("R6 x auto", x_addr, 4);
        check("R6 y reload", y_addr, 3);
        run_elems(8);
        check("R7 eow auto", eow, 1);
        check("R7 x start", x_addr, 5);

        // Wrap on both axes
        load_cfg(1025, 1, 2, 1, 0, 1, 1);
        pulse_start();
        run_elems(2);
        check("R8 y wrap", y_addr, 1025);
        check("R8 range set", range_err, 1);
        run_elems(1);
        check("R8 x wrap", x_addr, 0);
        run_elems(3);
        check("R8 range sticky", range_err, 1);

        // start together with a load is ignored
        cfg_x_start = 11'd7; cfg_y_start = 11'd8; start = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        start = 1'b0; cfg_load = 1'b0;
        check("R10 start with load", busy, 0);
        check("R2 range cleared", range_err, 0);

        // Out-of-range starts are reduced
        load_cfg(1030, 2047, 1, 1, 0, 0, 0);
        check("R2 x reduced", x_addr, 4);
        check("R2 y reduced", y_addr, 1021);
        check("R2 range flag", range_err, 1);

        // Longer self-advancing window with a start while busy
        load_cfg(100, 200, 39, 29, 0, 0, 1);
        pulse_start();
        run_elems(5);
        pulse_start();
        run_elems(1195);
        check("R7 long eow", eow, 1);
        check("R7 long idle", busy, 0);
        @(negedge clk);
        summary();
    end
endmodule